// File: doc/BRIEF.md
# Access-Aware DRAM Refresh Scheduler

This block sits next to an existing DRAM controller that serves one memory bank. It snoops every ordinary read or write (processor or DMA), takes the row field of the address and marks that row as recently opened in a one-bit-per-row map. Opening a row restores its charge, so such a row needs no refresh in the current retention interval.

A scan pointer walks the rows in ascending order at a rate set by a programmable prescaler. With the prescaler set so that a full pass takes half the retention time, no row goes unrefreshed for longer than the retention time. At each step the scheduler looks up the current row. If the row was opened since the last visit, the mark is cleared and the step costs nothing. Otherwise the scheduler raises a refresh request carrying the row number. The request stays up until the controller acknowledges it.

Rows that see no traffic are still refreshed on every pass. A sticky deadline-miss flag reports a scan step that found the previous request still unanswered. Two counters, one for refreshes requested and one for refreshes avoided, show how much refresh traffic was saved.

Top module: `row_refresh_sched`

## Requirements
- R1: After reset, refresh_req and deadline_miss are low, both counters read zero and every row counts as unopened, so the first pass requests a refresh for every row.
- R2: A scan step occurs once every step_div+1 clock cycles, counted from the release of the internal reset. Rows are visited in ascending order, and the pointer wraps from the last row to row 0.
- R3: At a step that finds the current row unopened, refresh_req rises on the next clock edge with refresh_row equal to that row, and refresh_count increments by one.
- R4: While refresh_req is high and refresh_ack is low, refresh_req and refresh_row hold their values. A cycle with both refresh_req and refresh_ack high drops refresh_req on the next edge and advances the scan pointer by one row.
- R5: At a step that finds the current row opened, no request is raised. skip_count increments by one, the pointer advances and the mark is cleared, so the next pass refreshes that row unless it is opened again.
- R6: A cycle with snoop_valid high marks the row given by snoop_addr[ROW_LSB +: ROW_W] (default: bits 8..0) as opened. All other address bits are ignored.
- R7: When a snooped access to a row and the clearing of that row's mark by the scan happen in the same cycle, the access wins and the mark stays set.
- R8: A scan step that occurs while refresh_req is high sets deadline_miss, which stays high until reset. That step does not examine or advance the pointer.
- R9: refresh_ack is ignored while refresh_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_div | input | 16 | Scan step period minus one, in clock cycles |
| snoop_valid | input | 1 | An ordinary access to the bank takes place this cycle |
| snoop_addr | input | 18 | Address of the snooped access |
| refresh_ack | input | 1 | Controller has accepted the pending refresh |
| refresh_req | output | 1 | Refresh requested for refresh_row |
| refresh_row | output | 9 | Row to refresh |
| deadline_miss | output | 1 | Sticky: a scan step found a request still pending |
| refresh_count | output | 16 | Refresh requests issued since reset |
| skip_count | output | 16 | Scan steps skipped because the row was already opened |

## Verification
A wrong bit in the row map shows up within one scan pass. A row that should be refreshed is skipped, or a refresh goes out that should not, and the next step for that row changes refresh_req and one of the two counters on the following edge. A wrong scan pointer shows at once on refresh_row at the next request. A handshake fault shows in the cycle after an acknowledge. The bench runs a cycle-level reference model built from the requirements and compares every output on every cycle, so any divergence is reported in the first cycle it reaches a port.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_WAIT = 1'b1
  } scan_state_t;
endpackage

// File: rtl/rfs_step_timer.sv
module rfs_step_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfs_touch_map.sv
module rfs_touch_map #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [ROW_W-1:0] set_row,
  input  logic             clr_en,
  input  logic [ROW_W-1:0] clr_row,
  input  logic [ROW_W-1:0] rd_row,
  output logic             rd_bit
);
  localparam int ROWS = 1 << ROW_W;

  logic [ROWS-1:0] mark_q;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic set_hit, clr_hit;
    assign set_hit = set_en && (set_row == ROW_W'(i));
    assign clr_hit = clr_en && (clr_row == ROW_W'(i));
    // An access in the same cycle takes priority over the scan clear.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mark_q[i] <= 1'b0;
      else if (set_hit) mark_q[i] <= 1'b1;
      else if (clr_hit) mark_q[i] <= 1'b0;
    end
  end

  assign rd_bit = mark_q[rd_row];
endmodule

// File: rtl/rfs_scan_ctrl.sv
module rfs_scan_ctrl
  import rfs_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             row_opened,
  input  logic             ack,
  output logic [ROW_W-1:0] scan_row,
  output logic             clr_en,
  output logic             req,
  output logic [ROW_W-1:0] req_row,
  output logic             miss,
  output logic [CNT_W-1:0] issued,
  output logic [CNT_W-1:0] skipped
);
  scan_state_t      st_q, st_d;
  logic [ROW_W-1:0] ptr_q, ptr_d, row_q, row_d;
  logic             miss_q, miss_d;
  logic [CNT_W-1:0] iss_q, iss_d, skp_q, skp_d;

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    row_d  = row_q;
    miss_d = miss_q;
    iss_d  = iss_q;
    skp_d  = skp_q;
    clr_en = 1'b0;
    case (st_q)
      SCAN_IDLE: begin
        if (tick) begin
          if (row_opened) begin
            clr_en = 1'b1;
            ptr_d  = ptr_q + 1'b1;
            skp_d  = skp_q + 1'b1;
          end else begin
            st_d  = SCAN_WAIT;
            row_d = ptr_q;
            iss_d = iss_q + 1'b1;
          end
        end
      end
      SCAN_WAIT: begin
        if (tick) miss_d = 1'b1;
        if (ack) begin
          st_d  = SCAN_IDLE;
          ptr_d = ptr_q + 1'b1;
        end
      end
      default: st_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SCAN_IDLE;
      ptr_q  <= '0;
      row_q  <= '0;
      miss_q <= 1'b0;
      iss_q  <= '0;
      skp_q  <= '0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      row_q  <= row_d;
      miss_q <= miss_d;
      iss_q  <= iss_d;
      skp_q  <= skp_d;
    end
  end

  assign scan_row = ptr_q;
  assign req      = (st_q == SCAN_WAIT);
  assign req_row  = row_q;
  assign miss     = miss_q;
  assign issued   = iss_q;
  assign skipped  = skp_q;
endmodule

// File: rtl/row_refresh_sched.sv
module row_refresh_sched #(
  parameter int ADDR_W  = 18,
  parameter int ROW_W   = 9,
  parameter int ROW_LSB = 0,
  parameter int DIV_W   = 16,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  step_div,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              refresh_ack,
  output logic              refresh_req,
  output logic [ROW_W-1:0]  refresh_row,
  output logic              deadline_miss,
  output logic [CNT_W-1:0]  refresh_count,
  output logic [CNT_W-1:0]  skip_count
);
  logic             rst_meta, rst_i;
  logic             tick, row_opened, clr_en;
  logic [ROW_W-1:0] scan_row, snoop_row;

  // Reset asserts at once and releases two edges after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  assign snoop_row = snoop_addr[ROW_LSB +: ROW_W];

  rfs_step_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_i), .div(step_div), .tick(tick)
  );

  rfs_touch_map #(.ROW_W(ROW_W)) u_map (
    .clk(clk), .rst_n(rst_i),
    .set_en(snoop_valid), .set_row(snoop_row),
    .clr_en(clr_en), .clr_row(scan_row),
    .rd_row(scan_row), .rd_bit(row_opened)
  );

  rfs_scan_ctrl #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_scan (
    .clk(clk), .rst_n(rst_i), .tick(tick), .row_opened(row_opened),
    .ack(refresh_ack), .scan_row(scan_row), .clr_en(clr_en),
    .req(refresh_req), .req_row(refresh_row), .miss(deadline_miss),
    .issued(refresh_count), .skipped(skip_count)
  );
endmodule

// File: rtl/row_refresh_sched_chk.sv
module row_refresh_sched_chk #(
  parameter int ROW_W = 9,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             refresh_ack,
  input logic             refresh_req,
  input logic [ROW_W-1:0] refresh_row,
  input logic             deadline_miss,
  input logic [CNT_W-1:0] refresh_count,
  input logic [CNT_W-1:0] skip_count
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack) |=> (refresh_req && $stable(refresh_row)));

  assert_ack_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && refresh_ack) |=> !refresh_req);

  assert_issue_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_req) |-> (refresh_count == $past(refresh_count) + 1'b1));

  assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !((refresh_count != $past(refresh_count)) && (skip_count != $past(skip_count))));

  assert_miss_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deadline_miss |=> deadline_miss);

  assert_miss_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadline_miss) |-> $past(refresh_req));
endmodule

bind row_refresh_sched row_refresh_sched_chk #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .refresh_ack(refresh_ack),
  .refresh_req(refresh_req), .refresh_row(refresh_row),
  .deadline_miss(deadline_miss), .refresh_count(refresh_count),
  .skip_count(skip_count)
);

// File: tb/row_refresh_sched_test.sv
module row_refresh_sched_test;
  localparam int ROWS = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] step_div;
  logic        snoop_valid;
  logic [17:0] snoop_addr;
  logic        refresh_ack;
  logic        refresh_req, deadline_miss;
  logic [8:0]  refresh_row;
  logic [15:0] refresh_count, skip_count;

  int tests = 0, fails = 0, cycles = 0;

  // Reference model state
  bit          m_map[ROWS];
  bit          m_req, m_miss;
  logic [8:0]  m_ptr, m_row;
  logic [15:0] m_iss, m_skp, m_cnt;
  int          m_edges;

  row_refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .step_div(step_div), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .refresh_ack(refresh_ack), .refresh_req(refresh_req),
    .refresh_row(refresh_row), .deadline_miss(deadline_miss),
    .refresh_count(refresh_count), .skip_count(skip_count)
  );

  always #10 clk = ~clk;

  function automatic logic [8:0] row_of(logic [17:0] a);
    return a[8:0];
  endfunction

  task automatic model_clear();
    for (int i = 0; i < ROWS; i++) m_map[i] = 1'b0;
    m_req = 0; m_miss = 0; m_ptr = '0; m_row = '0;
    m_iss = '0; m_skp = '0; m_cnt = '0;
  endtask

  // Model advances on each edge; two edges of synchronizer delay after reset.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_edges = 0;
      model_clear();
    end else begin
      m_edges++;
      if (m_edges > 2) begin
        bit tk, clr;
        tk    = (m_cnt == step_div);
        m_cnt = tk ? 16'd0 : m_cnt + 16'd1;
        clr   = 0;
        if (!m_req) begin
          if (tk) begin
            if (m_map[m_ptr]) begin clr = 1; m_skp++; end
            else begin m_req = 1; m_row = m_ptr; m_iss++; end
          end
        end else begin
          if (tk) m_miss = 1;                 // R8
          if (refresh_ack) begin m_req = 0; m_ptr++; end  // R9: only while pending
        end
        if (clr) begin m_map[m_ptr] = 0; m_ptr++; end
        if (snoop_valid) m_map[row_of(snoop_addr)] = 1;  // R7: access wins
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    chk("R3 R4 R9 refresh_req", refresh_req, m_req);
    if (m_req) chk("R2 R3 refresh_row", refresh_row, m_row);
    chk("R8 deadline_miss", deadline_miss, m_miss);
    chk("R3 refresh_count", refresh_count, m_iss);
    chk("R5 R6 R7 skip_count", skip_count, m_skp);
  endtask

  task automatic do_reset(int div);
    rst_n = 0; snoop_valid = 0; snoop_addr = '0; refresh_ack = 0;
    step_div = 16'(div);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // acc_pct: snoop rate; near_pct: share aimed at the scan row; ack_pct: ack rate
  task automatic run(int n, int acc_pct, int near_pct, int ack_pct);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare_all();
      snoop_valid = ($urandom_range(0, 99) < acc_pct);
      snoop_addr  = 18'($urandom());
      if ($urandom_range(0, 99) < near_pct) snoop_addr[8:0] = m_ptr;
      refresh_ack = ($urandom_range(0, 99) < ack_pct);
    end
    snoop_valid = 0; refresh_ack = 0;
  endtask

  initial begin
    int s;
    s = $urandom(32'd4711);
    rst_n = 0; step_div = 16'd3; snoop_valid = 0; snoop_addr = '0; refresh_ack = 0;

    // R1: reset state
    do_reset(3);
    chk("R1 req after reset", refresh_req, 0);
    chk("R1 miss after reset", deadline_miss, 0);
    chk("R1 refresh_count after reset", refresh_count, 0);
    chk("R1 skip_count after reset", skip_count, 0);

    // R1 R2: idle bank, prompt acks: every row refreshed, in order
    run(512 * 5 + 40, 0, 0, 100);
    chk("R1 first pass all refreshed", (refresh_count >= 16'd512) ? 1 : 0, 1);
    chk("R1 no skips without traffic", skip_count, 0);
    chk("R8 no miss with prompt ack", deadline_miss, 0);

    // R5 R6: heavy random traffic saves refreshes; ack R9 random while idle too
    do_reset(7);
    run(30000, 70, 5, 60);
    chk("R5 skips occur under traffic", (skip_count > 16'd0) ? 1 : 0, 1);

    // R7: accesses aimed at the scan row, frequent collisions with the clear
    do_reset(2);
    run(20000, 60, 80, 80);

    // R8: slow acknowledge with a short step period
    do_reset(1);
    run(4000, 20, 10, 10);
    chk("R8 miss raised by slow ack", deadline_miss, 1);
    run(200, 0, 0, 100);
    chk("R8 miss stays set", deadline_miss, 1);

    // R4: hold without ack
    do_reset(0);
    run(10, 0, 0, 0);
    chk("R4 req held without ack", refresh_req, 1);
    chk("R4 row held at 0", refresh_row, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule